// File: doc/BRIEF.md
# Source-Address Learning Table for a Two-Port Switch

This block remembers which physical port each station sits behind. When a frame arrives, the source address is learned against the port it came in on. When the host wants to send a frame, it presents the destination address. One cycle later the block answers with the port that owns that address, or with a flood code that tells the transmit path to send the frame out of both ports. Each port owns its own table. A table has 256 buckets, selected by folding the address, and each bucket holds four addresses with a small ageing counter per address.

Table upkeep runs through the same command interface. An age command steps every counter of one table. A purge command drops entries whose counter has reached the top value. A clear command empties a table. A state write sets whether the table may gain or lose entries. Age, purge and clear walk every bucket, one bucket per cycle, and the block holds `cmd_ready` low during that walk. Each table also reports how many addresses it currently holds.

Top module: `mac_fdb`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, both entry counts are 0, and any lookup returns the flood code.
- R2: Command codes on `cmd_op`: 0 clear, 1 learn, 2 lookup, 3 remove, 4 age, 5 purge, 6 state write, 7 no operation. A command takes effect only on a cycle where `cmd_valid` and `cmd_ready` are both 1. Code 7 changes nothing.
- R3: A lookup returns its answer on `rsp_dest` with `rsp_valid` high exactly one cycle after it is accepted. The answer codes are 2'b00 for port 0, 2'b01 for port 1 and 2'b11 for a miss in both tables (flood). A lookup never changes either table.
- R4: Learning an address that is already in the selected table leaves the count unchanged and resets that entry's ageing counter to 0.
- R5: The bucket index is the 8-bit XOR of the six address bytes. A new address goes into the first empty way of its bucket. If all four ways are full, it replaces the way with the highest ageing counter, taking the lowest way when several share that value. The count does not change on a replacement.
- R6: Age (code 4) on `cmd_port` adds one to every valid counter of that table, saturating at 3. It holds `cmd_ready` low for exactly 256 cycles after acceptance. Age works in every table state.
- R7: Purge (code 5) removes every entry of the selected table whose counter equals 3.
- R8: Remove (code 3) deletes the matching address from the selected table. Removing an absent address has no effect.
- R9: Table state codes on `cmd_state` are 0 learning (the reset state), 1 not learning, and 2 or 3 locked. Learning adds only in state 0. Remove and purge act only in states 0 and 1.
- R10: Clear (code 0) empties the selected table in any state, so its count returns to 0. The other table is left untouched.
- R11: Each count output equals the number of valid entries in that table, at most 1024.
- R12: When an address sits in both tables, a lookup answers port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can take a command (no table walk running) |
| cmd_op | input | 3 | Command code |
| cmd_port | input | 1 | Table selected by the command |
| cmd_key | input | 48 | MAC address for learn, lookup and remove |
| cmd_state | input | 2 | New table state for a state write |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_dest | output | 2 | Lookup answer: port 0, port 1 or flood |
| count_p0 | output | 11 | Entries held by the port 0 table |
| count_p1 | output | 11 | Entries held by the port 1 table |

## Verification
The hardest state to reach from the ports is a full bucket whose four entries carry different counter values, because replacement only shows up when a fifth address folds to the same index. The stimulus builds addresses whose last byte cancels the XOR of the other five, so all of them land in one chosen bucket. It interleaves learns with age walks so that the four entries end up with counters 3, 2, 1 and 0 before the fifth learn arrives. A second bucket is filled with four fresh entries to exercise the tie rule. The busy window is probed by pulsing a learn while an age walk is running and then showing that the address was never stored.

// File: rtl/fdb_pkg.sv
package fdb_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR  = 3'd0,
    OP_LEARN  = 3'd1,
    OP_LOOKUP = 3'd2,
    OP_REMOVE = 3'd3,
    OP_AGE    = 3'd4,
    OP_PURGE  = 3'd5,
    OP_STATE  = 3'd6,
    OP_NONE   = 3'd7
  } fdb_op_e;

  // table state codes
  localparam logic [1:0] TS_LEARN  = 2'd0;
  localparam logic [1:0] TS_FROZEN = 2'd1;

  // lookup answer codes
  localparam logic [1:0] DEST_P0    = 2'b00;
  localparam logic [1:0] DEST_P1    = 2'b01;
  localparam logic [1:0] DEST_FLOOD = 2'b11;

endpackage

// File: rtl/fdb_hash.sv
module fdb_hash #(
  parameter int KEY_W = 48,
  parameter int IDX_W = 8
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  localparam int NCH = (KEY_W + IDX_W - 1) / IDX_W;

  logic [NCH*IDX_W-1:0] padded;
  assign padded = (NCH*IDX_W)'(key);

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = idx ^ padded[i*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/fdb_bucket_logic.sv
module fdb_bucket_logic
  import fdb_pkg::*;
#(
  parameter int KEY_W = 48,
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  fdb_op_e               op,
  input  logic [KEY_W-1:0]      key,
  input  logic                  may_add,
  input  logic                  may_del,
  input  logic [WAYS-1:0]       vld_i,
  input  logic [WAYS*KEY_W-1:0] keys_i,
  input  logic [WAYS*AGE_W-1:0] ages_i,
  output logic [WAYS-1:0]       vld_o,
  output logic [WAYS*KEY_W-1:0] keys_o,
  output logic [WAYS*AGE_W-1:0] ages_o,
  output logic                  hit_o
);
  localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [AGE_W-1:0] AGE_TOP = {AGE_W{1'b1}};

  logic [WAYS-1:0] match;
  logic [WIDX-1:0] hit_way, free_way, old_way, tgt_way;
  logic            free_found;
  logic [AGE_W-1:0] old_age;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_i[w] && (keys_i[w*KEY_W +: KEY_W] == key);
  end

  assign hit_o = |match;

  // first matching way, first empty way, oldest way (lowest on tie)
  always_comb begin
    hit_way    = '0;
    free_way   = '0;
    free_found = 1'b0;
    old_way    = '0;
    old_age    = ages_i[0 +: AGE_W];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WIDX'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!vld_i[w] && !free_found) begin
        free_found = 1'b1;
        free_way   = WIDX'(w);
      end
    end
    for (int w = 1; w < WAYS; w++) begin
      if (ages_i[w*AGE_W +: AGE_W] > old_age) begin
        old_age = ages_i[w*AGE_W +: AGE_W];
        old_way = WIDX'(w);
      end
    end
    tgt_way = hit_o ? hit_way : (free_found ? free_way : old_way);
  end

  always_comb begin
    vld_o  = vld_i;
    keys_o = keys_i;
    ages_o = ages_i;
    case (op)
      OP_LEARN: begin
        if (may_add) begin
          vld_o[tgt_way]                  = 1'b1;
          keys_o[tgt_way*KEY_W +: KEY_W]  = key;
          ages_o[tgt_way*AGE_W +: AGE_W]  = '0;
        end
      end
      OP_REMOVE: begin
        if (may_del) begin
          for (int w = 0; w < WAYS; w++) begin
            if (match[w]) vld_o[w] = 1'b0;
          end
        end
      end
      OP_AGE: begin
        for (int w = 0; w < WAYS; w++) begin
          if (vld_i[w] && ages_i[w*AGE_W +: AGE_W] != AGE_TOP)
            ages_o[w*AGE_W +: AGE_W] = ages_i[w*AGE_W +: AGE_W] + 1'b1;
        end
      end
      OP_PURGE: begin
        if (may_del) begin
          for (int w = 0; w < WAYS; w++) begin
            if (vld_i[w] && ages_i[w*AGE_W +: AGE_W] == AGE_TOP) vld_o[w] = 1'b0;
          end
        end
      end
      OP_CLEAR: begin
        vld_o  = '0;
        ages_o = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fdb_table.sv
module fdb_table
  import fdb_pkg::*;
#(
  parameter int KEY_W = 48,
  parameter int IDX_W = 8,
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int BUCKETS = 1 << IDX_W,
  localparam int CNT_W   = $clog2(BUCKETS*WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  fdb_op_e          op,
  input  logic [KEY_W-1:0] key,
  input  logic             sweep_sel,
  input  logic [IDX_W-1:0] sweep_idx,
  input  logic             st_we,
  input  logic [1:0]       st_val,
  output logic             hit,
  output logic [CNT_W-1:0] count
);
  localparam int BCW = $clog2(WAYS + 1);

  logic [WAYS-1:0]       vld_q [BUCKETS];
  logic [WAYS*KEY_W-1:0] key_q [BUCKETS];
  logic [WAYS*AGE_W-1:0] age_q [BUCKETS];
  logic [BCW-1:0]        cnt_q [BUCKETS];
  logic [CNT_W-1:0]      total_q, total_d;
  logic [1:0]            state_q, state_d;

  logic [IDX_W-1:0]      h_idx, rd_idx;
  logic [WAYS-1:0]       n_vld;
  logic [WAYS*KEY_W-1:0] n_keys;
  logic [WAYS*AGE_W-1:0] n_ages;
  logic [BCW-1:0]        n_cnt;
  logic                  may_add, may_del, wr_en;

  fdb_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
    .key (key),
    .idx (h_idx)
  );

  assign rd_idx  = sweep_sel ? sweep_idx : h_idx;
  assign may_add = (state_q == TS_LEARN);
  assign may_del = (state_q == TS_LEARN) || (state_q == TS_FROZEN);

  fdb_bucket_logic #(.KEY_W(KEY_W), .WAYS(WAYS), .AGE_W(AGE_W)) u_bkt (
    .op      (op),
    .key     (key),
    .may_add (may_add),
    .may_del (may_del),
    .vld_i   (vld_q[rd_idx]),
    .keys_i  (key_q[rd_idx]),
    .ages_i  (age_q[rd_idx]),
    .vld_o   (n_vld),
    .keys_o  (n_keys),
    .ages_o  (n_ages),
    .hit_o   (hit)
  );

  assign n_cnt = BCW'($countones(n_vld));
  assign wr_en = apply;
  assign count = total_q;

  // next state
  always_comb begin
    total_d = total_q;
    state_d = state_q;
    if (wr_en) total_d = total_q + CNT_W'(n_cnt) - CNT_W'(cnt_q[rd_idx]);
    if (st_we) state_d = st_val;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      state_q <= TS_LEARN;
    end else begin
      total_q <= total_d;
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BUCKETS; b++) begin
        vld_q[b] <= '0;
        age_q[b] <= '0;
        cnt_q[b] <= '0;
      end
    end else if (wr_en) begin
      vld_q[rd_idx] <= n_vld;
      age_q[rd_idx] <= n_ages;
      cnt_q[rd_idx] <= n_cnt;
    end
  end

  // address storage needs no reset: guarded by the valid bits
  always_ff @(posedge clk) begin
    if (wr_en) key_q[rd_idx] <= n_keys;
  end
endmodule

// File: rtl/fdb_seq.sv
module fdb_seq
  import fdb_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  fdb_op_e          op_in,
  input  logic             port_in,
  output logic             ready,
  output logic             sweep_act,
  output fdb_op_e          sweep_op,
  output logic             sweep_port,
  output logic [IDX_W-1:0] sweep_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  typedef enum logic {S_IDLE, S_WALK} seq_e;

  seq_e             st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  fdb_op_e          op_q, op_d;
  logic             port_q, port_d;
  logic             walk_op;

  assign walk_op = (op_in == OP_CLEAR) || (op_in == OP_AGE) || (op_in == OP_PURGE);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    op_d   = op_q;
    port_d = port_q;
    case (st_q)
      S_IDLE: begin
        if (fire && walk_op) begin
          st_d   = S_WALK;
          idx_d  = '0;
          op_d   = op_in;
          port_d = port_in;
        end
      end
      default: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) st_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      op_q   <= OP_NONE;
      port_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      op_q   <= op_d;
      port_q <= port_d;
    end
  end

  assign ready      = (st_q == S_IDLE);
  assign sweep_act  = (st_q == S_WALK);
  assign sweep_op   = op_q;
  assign sweep_port = port_q;
  assign sweep_idx  = idx_q;
endmodule

// File: rtl/mac_fdb.sv
module mac_fdb
  import fdb_pkg::*;
#(
  parameter int KEY_W = 48,
  parameter int IDX_W = 8,
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int CNT_W = $clog2((1 << IDX_W)*WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_port,
  input  logic [KEY_W-1:0] cmd_key,
  input  logic [1:0]       cmd_state,
  output logic             rsp_valid,
  output logic [1:0]       rsp_dest,
  output logic [CNT_W-1:0] count_p0,
  output logic [CNT_W-1:0] count_p1
);
  localparam int NTAB = 2;

  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  fdb_op_e          op_in;
  logic             fire;
  logic             sweep_act, sweep_port;
  fdb_op_e          sweep_op;
  logic [IDX_W-1:0] sweep_idx;
  logic [NTAB-1:0]  hit;
  logic [CNT_W-1:0] cnt_w [NTAB];
  logic             rsp_valid_d;
  logic [1:0]       rsp_dest_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign op_in = fdb_op_e'(cmd_op);
  assign fire  = cmd_valid && cmd_ready;

  fdb_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fire       (fire),
    .op_in      (op_in),
    .port_in    (cmd_port),
    .ready      (cmd_ready),
    .sweep_act  (sweep_act),
    .sweep_op   (sweep_op),
    .sweep_port (sweep_port),
    .sweep_idx  (sweep_idx)
  );

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    logic    sel_cmd, single, apply, st_we;
    fdb_op_e op_t;

    assign sel_cmd = (cmd_port == 1'(t));
    assign single  = fire && sel_cmd && (op_in == OP_LEARN || op_in == OP_REMOVE);
    assign apply   = single || (sweep_act && sweep_port == 1'(t));
    assign op_t    = sweep_act ? sweep_op : op_in;
    assign st_we   = fire && sel_cmd && (op_in == OP_STATE);

    fdb_table #(.KEY_W(KEY_W), .IDX_W(IDX_W), .WAYS(WAYS), .AGE_W(AGE_W)) u_tab (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .apply     (apply),
      .op        (op_t),
      .key       (cmd_key),
      .sweep_sel (sweep_act),
      .sweep_idx (sweep_idx),
      .st_we     (st_we),
      .st_val    (cmd_state),
      .hit       (hit[t]),
      .count     (cnt_w[t])
    );
  end

  // lookup answer, port 0 first
  always_comb begin
    rsp_valid_d = fire && (op_in == OP_LOOKUP);
    if (hit[0])      rsp_dest_d = DEST_P0;
    else if (hit[1]) rsp_dest_d = DEST_P1;
    else             rsp_dest_d = DEST_FLOOD;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid <= 1'b0;
      rsp_dest  <= DEST_FLOOD;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (rsp_valid_d) rsp_dest <= rsp_dest_d;
    end
  end

  assign count_p0 = cnt_w[0];
  assign count_p1 = cnt_w[1];
endmodule

// File: rtl/fdb_checker.sv
module fdb_checker
  import fdb_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int WAYS  = 4,
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic             cmd_port,
  input logic [1:0]       cmd_state,
  input logic             rsp_valid,
  input logic [CNT_W-1:0] count_p0,
  input logic [CNT_W-1:0] count_p1
);
  localparam int BUCKETS = 1 << IDX_W;
  localparam int MAXN    = BUCKETS * WAYS;

  logic             acc;
  logic [1:0]       mst0, mst1;
  logic [IDX_W+1:0] busy;
  logic [2:0]       last_op;
  logic             last_port;

  assign acc = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst0      <= TS_LEARN;
      mst1      <= TS_LEARN;
      busy      <= '0;
      last_op   <= 3'd7;
      last_port <= 1'b0;
    end else begin
      if (acc && cmd_op == OP_STATE && !cmd_port) mst0 <= cmd_state;
      if (acc && cmd_op == OP_STATE &&  cmd_port) mst1 <= cmd_state;
      if (!cmd_ready) busy <= busy + 1'b1;
      else            busy <= '0;
      if (acc) begin
        last_op   <= cmd_op;
        last_port <= cmd_port;
      end
    end
  end

  assert_walk_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> busy == (IDX_W+2)'(BUCKETS));

  assert_walk_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == OP_AGE || cmd_op == OP_PURGE || cmd_op == OP_CLEAR)) |=> !cmd_ready);

  assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && cmd_op == OP_LOOKUP));

  assert_lookup_pure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_LOOKUP) |=> ($stable(count_p0) && $stable(count_p1)));

  assert_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_p0 <= CNT_W'(MAXN)) && (count_p1 <= CNT_W'(MAXN)));

  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, count_p0} <= {1'b0, $past(count_p0)} + 1'b1) &&
    ({1'b0, count_p1} <= {1'b0, $past(count_p1)} + 1'b1));

  assert_no_add_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_LEARN && !cmd_port && mst0 != TS_LEARN) |=> $stable(count_p0));

  assert_no_del_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_REMOVE && cmd_port && mst1[1]) |=> $stable(count_p1));

  assert_clear_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_ready) && last_op == OP_CLEAR) |->
      (last_port ? (count_p1 == '0) : (count_p0 == '0)));

  assert_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_NONE) |=> ($stable(count_p0) && $stable(count_p1) && !rsp_valid));
endmodule

bind mac_fdb fdb_checker #(.IDX_W(IDX_W), .WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_port  (cmd_port),
  .cmd_state (cmd_state),
  .rsp_valid (rsp_valid),
  .count_p0  (count_p0),
  .count_p1  (count_p1)
);

// File: tb/sim_mac_fdb.sv
module sim_mac_fdb;
  localparam logic [2:0] C_CLEAR = 3'd0, C_LEARN = 3'd1, C_LOOKUP = 3'd2,
                         C_REMOVE = 3'd3, C_AGE = 3'd4, C_PURGE = 3'd5,
                         C_STATE = 3'd6, C_NONE = 3'd7;

  logic        clk, rst_n, cmd_valid, cmd_ready, cmd_port, rsp_valid;
  logic [2:0]  cmd_op;
  logic [47:0] cmd_key;
  logic [1:0]  cmd_state, rsp_dest;
  logic [10:0] count_p0, count_p1;

  mac_fdb u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_key(cmd_key), .cmd_state(cmd_state),
    .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .count_p0(count_p0), .count_p1(count_p1)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference tables, built from the requirements
  bit          m_vld [2][256][4];
  logic [47:0] m_key [2][256][4];
  int          m_age [2][256][4];
  int          m_st  [2];

  logic [1:0] exp_q [$];
  string      tag_q [$];

  function automatic logic [7:0] fold(logic [47:0] k);
    return k[7:0] ^ k[15:8] ^ k[23:16] ^ k[31:24] ^ k[39:32] ^ k[47:40];
  endfunction

  function automatic logic [47:0] same_bucket(logic [7:0] idx, logic [7:0] n);
    return {n, 8'h11, 8'h22, 8'h33, 8'h44, n ^ 8'h11 ^ 8'h22 ^ 8'h33 ^ 8'h44 ^ idx};
  endfunction

  function automatic int m_count(int p);
    int c = 0;
    for (int b = 0; b < 256; b++) for (int w = 0; w < 4; w++) if (m_vld[p][b][w]) c++;
    return c;
  endfunction

  function automatic void m_learn(int p, logic [47:0] k);
    int b, v;
    if (m_st[p] != 0) return;
    b = int'(fold(k));
    for (int w = 0; w < 4; w++) if (m_vld[p][b][w] && m_key[p][b][w] == k) begin
      m_age[p][b][w] = 0; return;
    end
    for (int w = 0; w < 4; w++) if (!m_vld[p][b][w]) begin
      m_vld[p][b][w] = 1; m_key[p][b][w] = k; m_age[p][b][w] = 0; return;
    end
    v = 0;
    for (int w = 1; w < 4; w++) if (m_age[p][b][w] > m_age[p][b][v]) v = w;
    m_key[p][b][v] = k; m_age[p][b][v] = 0;
  endfunction

  function automatic void m_apply(logic [2:0] op, int p, logic [47:0] k, logic [1:0] s);
    int b;
    b = int'(fold(k));
    case (op)
      C_LEARN: m_learn(p, k);
      C_REMOVE: if (m_st[p] < 2)
        for (int w = 0; w < 4; w++) if (m_vld[p][b][w] && m_key[p][b][w] == k) m_vld[p][b][w] = 0;
      C_AGE:
        for (int i = 0; i < 256; i++) for (int w = 0; w < 4; w++)
          if (m_vld[p][i][w] && m_age[p][i][w] < 3) m_age[p][i][w]++;
      C_PURGE: if (m_st[p] < 2)
        for (int i = 0; i < 256; i++) for (int w = 0; w < 4; w++)
          if (m_vld[p][i][w] && m_age[p][i][w] == 3) m_vld[p][i][w] = 0;
      C_CLEAR:
        for (int i = 0; i < 256; i++) for (int w = 0; w < 4; w++) begin
          m_vld[p][i][w] = 0; m_age[p][i][w] = 0;
        end
      C_STATE: m_st[p] = int'(s);
      default: ;
    endcase
  endfunction

  function automatic logic [1:0] m_lookup(logic [47:0] k);
    int b;
    b = int'(fold(k));
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 4; w++) if (m_vld[p][b][w] && m_key[p][b][w] == k) return 2'(p);
    return 2'b11;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(string req);
    chk({req, " count p0"}, int'(count_p0), m_count(0));
    chk({req, " count p1"}, int'(count_p1), m_count(1));
  endtask

  // driver: called at a falling edge, returns at a falling edge
  task automatic issue(logic [2:0] op, bit p, logic [47:0] k, logic [1:0] s, string tag,
                       bit wait_done, output int busy);
    busy = 0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_port = p; cmd_key = k; cmd_state = s;
    if (op == C_LOOKUP) begin
      exp_q.push_back(m_lookup(k));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    cmd_valid = 0;
    m_apply(op, int'(p), k, s);
    if (wait_done) while (!cmd_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic run(logic [2:0] op, bit p, logic [47:0] k, logic [1:0] s);
    int b;
    issue(op, p, k, s, "", 1'b1, b);
  endtask

  task automatic look(logic [47:0] k, string tag);
    int b;
    issue(C_LOOKUP, 1'b0, k, 2'd0, tag, 1'b1, b);
  endtask

  // monitor: pops the expected answer for every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected response actual %b expected none", rsp_dest);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_dest !== e) begin
          n_fail++;
          $display("FAIL %s lookup actual %b expected %b", t, rsp_dest, e);
        end
      end
    end
  end

  task automatic finish_test();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    finish_test();
  end

  localparam logic [47:0] MA = 48'h0200_0000_0001;
  localparam logic [47:0] MB = 48'h0200_0000_0002;
  localparam logic [47:0] MC = 48'h0a0b_0c0d_0e0f;
  localparam logic [47:0] MD = 48'h0600_0000_7777;

  initial begin
    int busy;
    rst_n = 0; cmd_valid = 0; cmd_op = C_NONE; cmd_port = 0; cmd_key = '0; cmd_state = '0;
    for (int p = 0; p < 2; p++) begin
      m_st[p] = 0;
      for (int b = 0; b < 256; b++) for (int w = 0; w < 4; w++) begin
        m_vld[p][b][w] = 0; m_age[p][b][w] = 0; m_key[p][b][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk_counts("R1");
    look(MA, "R1 empty");

    // R3 basic learn and lookup
    run(C_LEARN, 0, MA, 0);
    run(C_LEARN, 1, MB, 0);
    look(MA, "R3 port0");
    look(MB, "R3 port1");
    look(MC, "R3 miss");
    chk_counts("R11 after learns");

    // R12 both tables hold the address, R8 remove
    run(C_LEARN, 1, MA, 0);
    look(MA, "R12 both");
    chk_counts("R11 dual");
    run(C_REMOVE, 1, MA, 0);
    look(MA, "R8 removed from p1");
    run(C_REMOVE, 1, MC, 0);
    chk_counts("R8 absent remove");

    // R5 full bucket with distinct ages, R4 refresh, R6 age, R7 purge
    run(C_LEARN, 0, same_bucket(8'h5a, 8'd1), 0);
    issue(C_AGE, 0, '0, 0, "", 1'b1, busy);
    chk("R6 walk length", busy, 256);
    run(C_LEARN, 0, same_bucket(8'h5a, 8'd2), 0);
    run(C_AGE, 0, '0, 0);
    run(C_LEARN, 0, same_bucket(8'h5a, 8'd3), 0);
    run(C_AGE, 0, '0, 0);
    run(C_LEARN, 0, same_bucket(8'h5a, 8'd4), 0);
    chk_counts("R5 bucket full");
    run(C_LEARN, 0, same_bucket(8'h5a, 8'd5), 0);
    chk_counts("R5 replace keeps count");
    look(same_bucket(8'h5a, 8'd1), "R5 oldest evicted");
    look(same_bucket(8'h5a, 8'd5), "R5 newcomer");
    look(same_bucket(8'h5a, 8'd2), "R5 survivor");
    run(C_LEARN, 0, same_bucket(8'h5a, 8'd2), 0);
    chk_counts("R4 relearn count");
    run(C_AGE, 0, '0, 0);
    run(C_AGE, 0, '0, 0);
    run(C_PURGE, 0, '0, 0);
    chk_counts("R7 purge");
    look(same_bucket(8'h5a, 8'd3), "R7 purged");
    look(same_bucket(8'h5a, 8'd2), "R4 refreshed survives");
    look(MB, "R6 other table untouched");

    // R9 table states
    run(C_STATE, 1, '0, 2'd2);
    run(C_LEARN, 1, MC, 0);
    look(MC, "R9 locked no add");
    run(C_REMOVE, 1, MB, 0);
    look(MB, "R9 locked no remove");
    run(C_AGE, 1, '0, 0); run(C_AGE, 1, '0, 0); run(C_AGE, 1, '0, 0);
    run(C_PURGE, 1, '0, 0);
    chk_counts("R9 locked purge");
    run(C_STATE, 1, '0, 2'd1);
    run(C_LEARN, 1, MC, 0);
    look(MC, "R9 frozen no add");
    run(C_REMOVE, 1, MB, 0);
    look(MB, "R9 frozen remove");
    run(C_STATE, 1, '0, 2'd0);
    run(C_LEARN, 1, MC, 0);
    look(MC, "R9 learning again");

    // R5 tie: four fresh entries, fifth replaces lowest way
    for (int i = 1; i <= 5; i++) run(C_LEARN, 1, same_bucket(8'h33, 8'(i)), 0);
    look(same_bucket(8'h33, 8'd1), "R5 tie lowest way");
    look(same_bucket(8'h33, 8'd2), "R5 tie keep");
    look(same_bucket(8'h33, 8'd5), "R5 tie new");
    chk_counts("R5 tie count");

    // R2 no accept while busy, code 7 no effect
    issue(C_AGE, 1, '0, 0, "", 1'b0, busy);
    chk("R2 busy after walk start", int'(cmd_ready), 0);
    cmd_valid = 1; cmd_op = C_LEARN; cmd_port = 0; cmd_key = MD;
    @(negedge clk);
    cmd_valid = 0;
    while (!cmd_ready) @(negedge clk);
    look(MD, "R2 ignored while busy");
    run(C_NONE, 0, MD, 0);
    chk_counts("R2 code 7");
    look(MD, "R2 code 7 no learn");

    // R10 clear works even when locked, other table kept
    run(C_STATE, 0, '0, 2'd3);
    run(C_CLEAR, 0, '0, 0);
    chk("R10 cleared", int'(count_p0), 0);
    chk_counts("R10 clear");
    look(same_bucket(8'h5a, 8'd2), "R10 gone");
    look(MC, "R10 other table kept");

    repeat (3) @(negedge clk);
    chk("R3 all responses seen", exp_q.size(), 0);
    finish_test();
  end
endmodule